// File: doc/BRIEF.md
# Periodic Multi-Row Scrub Scheduler

This block paces a configuration-memory scrubber. A prescaled interval timer raises a scan request every (DELAY+1)·2^PRESCALE_W clock cycles. The default prescale width is 16 and the delay setting is 32 bits wide, so the interval reaches about 2^48 cycles. Each request is offered to a set of row scanners that run independently of one another. Each scanner has its own scan length. A row that is idle on a request is launched with a single-cycle start pulse. A row that is still scanning lets that request pass and waits for a later one. No request is queued.

The block records which rows are scanning and which rows have finished a clean first pass since enable. It raises a ready flag once every row has completed such a pass. If any row reports an uncorrectable result before its first clean pass, a sticky error flag is raised and ready stays low. Scrubbing is off after reset and is turned on with an enable input. Turning it off stops new launches but lets scans already running finish.

Top module: `scrub_scheduler`

## Requirements
- R1: After reset, row_start, row_busy, row_pass, ready and err_flag are all 0.
- R2: When en is first seen high at a rising edge, every idle row receives a start pulse at the next rising edge. That is the second edge at which en is high, so no full interval is waited for.
- R3: After the first request, further requests follow at intervals of exactly (delay_cfg+1)·2^PRESCALE_W cycles for as long as en stays high.
- R4: A start pulse lasts exactly one cycle and is given only to a row that is idle when the request arrives. A busy row skips that request.
- R5: row_busy[i] rises together with row_start[i] and falls at the edge where row_done[i] is seen. A row_done on an idle row has no effect.
- R6: row_pass[i] is set by a row_done[i] with row_err[i]=0 on a busy row while en is high. It is cleared while en is low.
- R7: ready is 1 exactly when every row_pass bit is 1 and err_flag is 0.
- R8: err_flag is set by a row_done with row_err=1 on a busy row that has not yet passed, while en is high. It stays set until reset. An error reported after a row has passed does not set it.
- R9: While en is low no start pulse is issued, and rows already scanning still clear row_busy on their row_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Scrub enable |
| delay_cfg | input | DELAY_W | Interval multiplier; interval = (delay_cfg+1)·2^PRESCALE_W |
| row_done | input | NUM_ROWS | Per-row scan-complete pulse |
| row_err | input | NUM_ROWS | Per-row uncorrectable flag, valid with row_done |
| row_start | output | NUM_ROWS | Per-row one-cycle launch pulse |
| row_busy | output | NUM_ROWS | Row scan in progress |
| row_pass | output | NUM_ROWS | Row completed a clean pass since enable |
| ready | output | 1 | All rows passed and no error |
| err_flag | output | 1 | Sticky first-pass error |

## Verification
The bench builds the block with PRESCALE_W=4 and keeps five rows. This makes the interval 16·(delay_cfg+1) cycles, so a whole period is tens of cycles long. The bench sweeps delay_cfg from 0 to 2 and runs several scan-length mixes in each setting. The mixes include rows that are shorter than an interval and rows that are longer, which brings skipped requests into reach. The runs also cover a first-pass error, an error reported after a clean pass, stray done pulses on idle rows, and a disable in the middle of a scan. Every expected output is computed cycle by cycle from the period formula.

// File: rtl/scrub_pkg.sv
// Shared defaults and types for the scrub scheduler.
package scrub_pkg;
    localparam int DEF_ROWS       = 5;
    localparam int DEF_DELAY_W    = 32;
    localparam int DEF_PRESCALE_W = 16;

    // Interval timer phase: waiting for the first request, or counting periods.
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/scrub_interval_timer.sv
// Interval timer: issues a one-cycle request on the first enabled edge,
// then once every (delay_cfg+1)*2^PRESCALE_W cycles.
// Assumes delay_cfg changes only while en is low. A value lowered below the
// running count still ends the current interval.
module scrub_interval_timer
    import scrub_pkg::*;
#(
    parameter int DELAY_W    = DEF_DELAY_W,
    parameter int PRESCALE_W = DEF_PRESCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [DELAY_W-1:0] delay_cfg,
    output logic               req
);
    localparam logic [PRESCALE_W-1:0] PRE_MAX = '1;

    tmr_state_e             state;
    logic [PRESCALE_W-1:0]  pre_cnt;
    logic [DELAY_W-1:0]     dly_cnt;

    // Prescaler, delay counter and request pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= TMR_IDLE;
            pre_cnt <= '0;
            dly_cnt <= '0;
            req     <= 1'b0;
        end else begin
            case (state)
                TMR_IDLE: begin
                    req   <= 1'b1;
                    state <= TMR_RUN;
                end
                default: begin
                    if (pre_cnt == PRE_MAX) begin
                        pre_cnt <= '0;
                        if (dly_cnt >= delay_cfg) begin
                            dly_cnt <= '0;
                            req     <= 1'b1;
                        end else begin
                            dly_cnt <= dly_cnt + 1'b1;
                            req     <= 1'b0;
                        end
                    end else begin
                        pre_cnt <= pre_cnt + 1'b1;
                        req     <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Requests never come back to back (the interval is at least 2 cycles).
    assert_req_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // A request is only raised while enabled.
    assert_req_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req);
endmodule

// File: rtl/scrub_row_ctrl.sv
// Per-row launcher and status: launches an idle row on a request, drops the
// request if the row is busy, and tracks the row's first clean pass.
// Assumes row_err is meaningful only together with row_done.
module scrub_row_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic done,
    input  logic err,
    output logic start,
    output logic busy,
    output logic pass,
    output logic first_fail
);
    logic launch;

    // A launch happens when a request meets an idle, enabled row.
    always_comb launch = req && en && !busy;

    // Start pulse and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            busy  <= 1'b0;
        end else begin
            start <= launch;
            if (launch)
                busy <= 1'b1;
            else if (done)
                busy <= 1'b0;
        end
    end

    // First clean pass since enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            pass <= 1'b0;
        else if (busy && done && !err)
            pass <= 1'b1;
    end

    // Uncorrectable report before this row's first clean pass.
    always_comb first_fail = en && busy && done && err && !pass;

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    assert_start_marks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);

    assert_idle_done_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req && en)) |=> !busy);
endmodule

// File: rtl/scrub_ready_tracker.sv
// Readiness tracker: raises ready when every row passed, and keeps a
// sticky error flag for any first-pass uncorrectable report.
module scrub_ready_tracker #(
    parameter int NUM_ROWS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] pass,
    input  logic [NUM_ROWS-1:0] first_fail,
    output logic                ready,
    output logic                err_flag
);
    // Sticky error: set on any first-pass failure, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (|first_fail)
            err_flag <= 1'b1;
    end

    // Ready needs every row passed and no error seen.
    always_comb ready = (&pass) && !err_flag;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_ready_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !ready);
endmodule

// File: rtl/scrub_scheduler.sv
// Top of the scrub scheduler: one interval timer feeding NUM_ROWS
// independent row controllers and a readiness tracker.
// Assumes the row scanners are external and answer with a done pulse.
module scrub_scheduler
    import scrub_pkg::*;
#(
    parameter int NUM_ROWS   = DEF_ROWS,
    parameter int DELAY_W    = DEF_DELAY_W,
    parameter int PRESCALE_W = DEF_PRESCALE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [DELAY_W-1:0]  delay_cfg,
    input  logic [NUM_ROWS-1:0] row_done,
    input  logic [NUM_ROWS-1:0] row_err,
    output logic [NUM_ROWS-1:0] row_start,
    output logic [NUM_ROWS-1:0] row_busy,
    output logic [NUM_ROWS-1:0] row_pass,
    output logic                ready,
    output logic                err_flag
);
    logic                scan_req;
    logic [NUM_ROWS-1:0] first_fail;

    scrub_interval_timer #(
        .DELAY_W    (DELAY_W),
        .PRESCALE_W (PRESCALE_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .delay_cfg (delay_cfg),
        .req       (scan_req)
    );

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        scrub_row_ctrl u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en),
            .req        (scan_req),
            .done       (row_done[i]),
            .err        (row_err[i]),
            .start      (row_start[i]),
            .busy       (row_busy[i]),
            .pass       (row_pass[i]),
            .first_fail (first_fail[i])
        );
    end

    scrub_ready_tracker #(
        .NUM_ROWS (NUM_ROWS)
    ) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass       (row_pass),
        .first_fail (first_fail),
        .ready      (ready),
        .err_flag   (err_flag)
    );

    assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (row_start == '0));

    assert_pass_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (row_pass == '0));
endmodule

// File: tb/sim_scrub_scheduler.sv
module sim_scrub_scheduler;
    localparam int ROWS = 5;
    localparam int PW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [31:0]     dly = '0;
    logic [ROWS-1:0] done_d = '0, err_d = '0;
    logic [ROWS-1:0] row_start, row_busy, row_pass;
    logic            ready, err_flag;

    always #4 clk = ~clk;

    scrub_scheduler #(.NUM_ROWS(ROWS), .DELAY_W(32), .PRESCALE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .delay_cfg(dly),
        .row_done(done_d), .row_err(err_d),
        .row_start(row_start), .row_busy(row_busy), .row_pass(row_pass),
        .ready(ready), .err_flag(err_flag));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference state, derived from the requirements.
    int  n_en;
    bit  m_req, m_req_first, m_err;
    bit  [ROWS-1:0] m_start, m_busy, m_pass, stray;
    int  cnt [ROWS];
    int  dur [ROWS];
    bit  eplan [ROWS];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; en = 0; done_d = '0; err_d = '0; stray = '0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1;
        n_en = 0; m_req = 0; m_req_first = 0; m_err = 0;
        m_start = '0; m_busy = '0; m_pass = '0;
        for (int r = 0; r < ROWS; r++) begin cnt[r] = 0; eplan[r] = 0; end
        // R1: reset state
        chk("R1 start", int'(row_start), 0);
        chk("R1 busy", int'(row_busy), 0);
        chk("R1 pass", int'(row_pass), 0);
        chk("R1 ready", int'(ready), 0);
        chk("R1 err", int'(err_flag), 0);
    endtask

    // One clock: predict, clock, compare, then drive the row stubs.
    task automatic cycle();
        int per;
        bit n_req, n_first, n_err;
        bit [ROWS-1:0] n_start, n_busy, n_pass;
        bit skip;
        per = (int'(dly) + 1) * (1 << PW);
        n_err = m_err;
        skip = 0;
        for (int r = 0; r < ROWS; r++) begin
            n_start[r] = m_req && en && !m_busy[r];
            if (m_req && en && m_busy[r]) skip = 1;
            n_busy[r]  = n_start[r] ? 1'b1 : (done_d[r] ? 1'b0 : m_busy[r]);
            n_pass[r]  = !en ? 1'b0 : (m_pass[r] | (m_busy[r] & done_d[r] & ~err_d[r]));
            if (en && m_busy[r] && done_d[r] && err_d[r] && !m_pass[r]) n_err = 1;
        end
        if (en) begin
            n_req = (n_en % per) == 0;
            n_first = (n_en == 0);
            n_en++;
        end else begin
            n_req = 0; n_first = 0; n_en = 0;
        end
        @(posedge clk);
        #2;
        m_start = n_start; m_busy = n_busy; m_pass = n_pass; m_err = n_err;
        if (m_req_first)      chk("R2 first start", int'(row_start), int'(m_start));
        else if (skip)        chk("R4 start skip", int'(row_start), int'(m_start));
        else                  chk("R3 start period", int'(row_start), int'(m_start));
        m_req = n_req; m_req_first = n_first;
        if (!en) chk("R9 busy disabled", int'(row_busy), int'(m_busy));
        else     chk("R5 busy", int'(row_busy), int'(m_busy));
        chk("R6 pass", int'(row_pass), int'(m_pass));
        chk("R8 err", int'(err_flag), int'(m_err));
        chk("R7 ready", int'(ready), int'((&m_pass) && !m_err));
        // Row stubs.
        for (int r = 0; r < ROWS; r++) begin
            done_d[r] = 0; err_d[r] = 0;
            if (cnt[r] > 0) begin
                cnt[r]--;
                if (cnt[r] == 0) begin done_d[r] = 1; err_d[r] = eplan[r]; end
            end
            if (row_start[r]) cnt[r] = dur[r];
        end
        done_d = done_d | stray;
        stray = '0;
    endtask

    task automatic run(int k);
        for (int i = 0; i < k; i++) begin
            if (i % 13 == 7) stray = 5'b00001 << (i % ROWS);
            cycle();
        end
    endtask

    initial begin
        for (int d = 0; d < 3; d++) begin
            int per;
            per = (d + 1) * (1 << PW);
            // Short scans, no errors: ready expected.
            do_reset();
            dly = d;
            for (int r = 0; r < ROWS; r++) dur[r] = 3 + 2 * r;
            en = 1;
            run(4 * per);
            chk("R7 ready after clean pass", int'(ready), 1);
            // Error after passing must not raise the flag.
            eplan[0] = 1;
            run(2 * per);
            chk("R8 late error ignored", int'(err_flag), 0);

            // Long scans: some rows skip requests.
            do_reset();
            dly = d;
            dur[0] = per + 5; dur[1] = 2 * per; dur[2] = 10; dur[3] = per - 1; dur[4] = per;
            en = 1;
            run(7 * per);

            // First-pass error on row 2.
            do_reset();
            dly = d;
            for (int r = 0; r < ROWS; r++) dur[r] = 4 + r;
            eplan[2] = 1;
            en = 1;
            run(3 * per);
            chk("R8 sticky err", int'(err_flag), 1);
            chk("R8 ready low", int'(ready), 0);

            // Disable during a scan, then re-enable.
            do_reset();
            dly = d;
            for (int r = 0; r < ROWS; r++) dur[r] = per + 3 * r;
            en = 1;
            run(per + 3);
            en = 0;
            run(3 * per);
            chk("R9 scans drained", int'(row_busy), 0);
            en = 1;
            run(4 * per);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule